// File: doc/BRIEF.md
# Mean Squared Residue Engine

The block scores a ROWS-by-COLS submatrix of signed fixed-point expression values by its mean squared residue. Software first fills the matrix through a single write port that takes a row index, a column index and a data word. A start pulse then runs a fixed schedule of phases, and the block reports the score with a one-cycle done flag. A lower score marks a more coherent submatrix. Input values are signed Q8.8 words, and the score is an unsigned integer in squared input units (Q16.16 raw).

The datapath is arranged around one lane per matrix row. In the first pass each lane walks across the columns one at a time. It accumulates its row sum while an adder tree across the lanes forms the sum of the current column. Each lane has its own sequential divider. The lanes first produce the row means together. They are then handed the column sums in rounds of ROWS to produce the column means. Lane 0 finally produces the overall mean from the sum of the row sums. A second column walk forms one residue per lane per cycle and accumulates the squares. A last division by the cell count gives the score.

Top module: `msr_engine`

## Requirements
- R1: While the block is idle, a write with `wr_en` high stores `wr_data` at element (`wr_row`, `wr_col`), and the next computation uses the stored matrix.
- R2: The mean of row i is the sum of row i divided by COLS. The mean of column j is the sum of column j divided by ROWS. Both quotients are truncated toward zero.
- R3: The overall mean is the sum of the row sums divided by ROWS*COLS, truncated toward zero.
- R4: The residue of element (i,j) is the element, minus its row mean, minus its column mean, plus the overall mean.
- R5: `msr` is the sum of the squared residues divided by ROWS*COLS, truncated. It is an unsigned integer 2*(DW+2) bits wide in squared input units.
- R6: `done` is high for exactly one cycle per run. `busy` is high from the cycle after an accepted start and is low in the cycle where `done` is high.
- R7: `msr` keeps its value from one `done` until the next `done`, including while a new run is in progress.
- R8: A write issued while `busy` is high is ignored and leaves the matrix unchanged.
- R9: A start pulse while `busy` is high is ignored and does not lengthen or repeat the run.
- R10: After reset, `busy`, `done` and `msr` are all zero.
- R11: The cycle count from start to `done` is the same for every matrix content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Matrix write strobe |
| wr_row | input | $clog2(ROWS) | Row index of the write |
| wr_col | input | $clog2(COLS) | Column index of the write |
| wr_data | input | DW | Signed element value |
| start | input | 1 | Begin a computation (idle only) |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle result strobe |
| msr | output | 2*(DW+2) | Mean squared residue result |

## Verification
The bench builds the engine with 4 rows and 6 columns. With these values the column count exceeds the lane count, so the column means take two division rounds, and the second round leaves two lanes idle. The shape is also not square and has a column count that is not a power of two. This exposes any swap of the row and column divisors and any error in the lane-to-column mapping. Patterns are chosen so that negative means truncate differently from a floor, and full-scale values of both signs stretch the residue and accumulator widths.

// File: rtl/msr_pkg.sv
package msr_pkg;
   typedef enum logic [3:0] {
      PH_IDLE,
      PH_SUM,
      PH_RDIV,
      PH_RWAIT,
      PH_CDIV,
      PH_CWAIT,
      PH_ADIV,
      PH_AWAIT,
      PH_RES,
      PH_FDIV,
      PH_FWAIT
   } phase_t;
endpackage

// File: rtl/msr_div.sv
// Sequential signed divider, quotient truncated toward zero, one bit per cycle.
module msr_div #(
   parameter int W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                go,
   input  logic signed [W-1:0] num,
   input  logic signed [W-1:0] den,
   output logic                busy,
   output logic signed [W-1:0] q
);
   localparam int CW = $clog2(W + 1);

   logic [W-1:0]  quo, dmag, num_mag, den_mag;
   logic [W:0]    rem, shifted, trial;
   logic [CW-1:0] cnt;
   logic          neg;

   assign num_mag = num[W-1] ? $unsigned(-num) : $unsigned(num);
   assign den_mag = den[W-1] ? $unsigned(-den) : $unsigned(den);
   assign shifted = {rem[W-1:0], quo[W-1]};
   assign trial   = shifted - {1'b0, dmag};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quo  <= '0;
         dmag <= '0;
         rem  <= '0;
         cnt  <= '0;
         neg  <= 1'b0;
         busy <= 1'b0;
      end else if (go) begin
         quo  <= num_mag;
         dmag <= den_mag;
         rem  <= '0;
         cnt  <= CW'(W);
         neg  <= num[W-1] ^ den[W-1];
         busy <= 1'b1;
      end else if (busy) begin
         rem  <= trial[W] ? shifted : trial;
         quo  <= {quo[W-2:0], ~trial[W]};
         cnt  <= cnt - 1'b1;
         if (cnt == CW'(1)) busy <= 1'b0;
      end
   end

   assign q = neg ? -$signed(quo) : $signed(quo);

   // R2: restoring step keeps the partial remainder below the divisor
   p_rem_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (rem < {1'b0, dmag}));
endmodule

// File: rtl/msr_lane.sv
// One row lane: row accumulator, squared-residue accumulator, private divider.
module msr_lane #(
   parameter int DW = 16,
   parameter int SW = 23,
   parameter int RW = 18,
   parameter int W  = 43
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 acc_en,
   input  logic signed [DW-1:0] elem,
   input  logic                 res_en,
   input  logic signed [RW-1:0] res,
   input  logic                 go,
   input  logic signed [W-1:0]  num,
   input  logic signed [W-1:0]  den,
   output logic signed [SW-1:0] row_sum,
   output logic [W-1:0]         sq_sum,
   output logic                 busy,
   output logic signed [W-1:0]  q
);
   logic signed [2*RW-1:0] sq;
   assign sq = res * res;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_sum <= '0;
         sq_sum  <= '0;
      end else if (clr) begin
         row_sum <= '0;
         sq_sum  <= '0;
      end else begin
         if (acc_en) row_sum <= row_sum + {{(SW-DW){elem[DW-1]}}, elem};
         if (res_en) sq_sum  <= sq_sum + {{(W-2*RW){1'b0}}, $unsigned(sq)};
      end
   end

   msr_div #(.W(W)) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .go   (go),
      .num  (num),
      .den  (den),
      .busy (busy),
      .q    (q)
   );

   // R5: the squared-residue accumulator never decreases during the residue walk
   p_sq_grows_r5: assert property (@(posedge clk) disable iff (!rst_n)
      res_en |=> (sq_sum >= $past(sq_sum)));
endmodule

// File: rtl/msr_engine.sv
module msr_engine #(
   parameter int ROWS = 8,
   parameter int COLS = 8,
   parameter int DW   = 16,
   localparam int RIW = (ROWS > 1) ? $clog2(ROWS) : 1,
   localparam int CIW = (COLS > 1) ? $clog2(COLS) : 1,
   localparam int MW  = 2 * (DW + 2)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [RIW-1:0]       wr_row,
   input  logic [CIW-1:0]       wr_col,
   input  logic signed [DW-1:0] wr_data,
   input  logic                 start,
   output logic                 busy,
   output logic                 done,
   output logic [MW-1:0]        msr
);
   import msr_pkg::*;

   localparam int CELLS = ROWS * COLS;
   localparam int CLW   = $clog2(CELLS);
   localparam int SW    = DW + CLW + 1;
   localparam int RW    = DW + 2;
   localparam int W     = 2 * RW + CLW + 1;
   localparam int NRND  = (COLS + ROWS - 1) / ROWS;
   localparam int RNW   = $clog2(NRND + 1);

   if (ROWS < 2 || COLS < 2 || DW < 2) begin : g_bad_params
      $error("msr_engine: ROWS, COLS and DW must each be at least 2");
   end

   phase_t              ph;
   logic [CIW-1:0]      col;
   logic [RNW-1:0]      rnd;
   logic signed [DW-1:0] mem      [ROWS][COLS];
   logic signed [SW-1:0] csum_q   [COLS];
   logic signed [DW-1:0] row_mean [ROWS];
   logic signed [DW-1:0] col_mean [COLS];
   logic signed [DW-1:0] all_mean;
   logic signed [SW-1:0] total_q;

   logic                l_go   [ROWS];
   logic                l_busy [ROWS];
   logic signed [W-1:0] l_num  [ROWS];
   logic signed [W-1:0] l_den  [ROWS];
   logic signed [W-1:0] l_q    [ROWS];
   logic signed [SW-1:0] l_rsum [ROWS];
   logic [W-1:0]        l_sq   [ROWS];
   logic signed [RW-1:0] l_res  [ROWS];
   logic [ROWS-1:0]     lane_unused;

   logic                any_busy;
   logic signed [SW-1:0] csum_now, rsum_tot;
   logic [W-1:0]        sq_tot;
   logic                lane_clr;

   assign busy     = (ph != PH_IDLE);
   assign lane_clr = (ph == PH_IDLE) && start;

   always_comb begin
      any_busy = 1'b0;
      csum_now = '0;
      rsum_tot = '0;
      sq_tot   = '0;
      for (int i = 0; i < ROWS; i++) begin
         any_busy = any_busy | l_busy[i];
         csum_now = csum_now + {{(SW-DW){mem[i][col][DW-1]}}, mem[i][col]};
         rsum_tot = rsum_tot + l_rsum[i];
         sq_tot   = sq_tot + l_sq[i];
      end
   end

   for (genvar g = 0; g < ROWS; g++) begin : g_lane
      assign l_res[g] = {{2{mem[g][col][DW-1]}}, mem[g][col]}
                      - {{2{row_mean[g][DW-1]}}, row_mean[g]}
                      - {{2{col_mean[col][DW-1]}}, col_mean[col]}
                      + {{2{all_mean[DW-1]}}, all_mean};
      assign lane_unused[g] = ^l_q[g][W-1:DW];

      always_comb begin
         l_go[g]  = 1'b0;
         l_num[g] = '0;
         l_den[g] = '0;
         case (ph)
            PH_RDIV: begin
               l_go[g]  = 1'b1;
               l_num[g] = {{(W-SW){l_rsum[g][SW-1]}}, l_rsum[g]};
               l_den[g] = W'(COLS);
            end
            PH_CDIV: begin
               for (int j = 0; j < COLS; j++) begin
                  if ((j % ROWS) == g && (j / ROWS) == int'(rnd)) begin
                     l_go[g]  = 1'b1;
                     l_num[g] = {{(W-SW){csum_q[j][SW-1]}}, csum_q[j]};
                     l_den[g] = W'(ROWS);
                  end
               end
            end
            PH_ADIV: begin
               if (g == 0) begin
                  l_go[g]  = 1'b1;
                  l_num[g] = {{(W-SW){total_q[SW-1]}}, total_q};
                  l_den[g] = W'(CELLS);
               end
            end
            PH_FDIV: begin
               if (g == 0) begin
                  l_go[g]  = 1'b1;
                  l_num[g] = $signed(sq_tot);
                  l_den[g] = W'(CELLS);
               end
            end
            default: ;
         endcase
      end

      msr_lane #(.DW(DW), .SW(SW), .RW(RW), .W(W)) u_lane (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr    (lane_clr),
         .acc_en (ph == PH_SUM),
         .elem   (mem[g][col]),
         .res_en (ph == PH_RES),
         .res    (l_res[g]),
         .go     (l_go[g]),
         .num    (l_num[g]),
         .den    (l_den[g]),
         .row_sum(l_rsum[g]),
         .sq_sum (l_sq[g]),
         .busy   (l_busy[g]),
         .q      (l_q[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph       <= PH_IDLE;
         col      <= '0;
         rnd      <= '0;
         done     <= 1'b0;
         msr      <= '0;
         all_mean <= '0;
         total_q  <= '0;
         for (int i = 0; i < ROWS; i++) begin
            row_mean[i] <= '0;
            for (int j = 0; j < COLS; j++) mem[i][j] <= '0;
         end
         for (int j = 0; j < COLS; j++) begin
            csum_q[j]   <= '0;
            col_mean[j] <= '0;
         end
      end else begin
         done <= 1'b0;
         if (wr_en && ph == PH_IDLE) mem[wr_row][wr_col] <= wr_data;
         case (ph)
            PH_IDLE: if (start) begin
               col <= '0;
               ph  <= PH_SUM;
            end
            PH_SUM: begin
               csum_q[col] <= csum_now;
               if (col == CIW'(COLS - 1)) ph <= PH_RDIV;
               else col <= col + 1'b1;
            end
            PH_RDIV: begin
               total_q <= rsum_tot;
               ph      <= PH_RWAIT;
            end
            PH_RWAIT: if (!any_busy) begin
               for (int i = 0; i < ROWS; i++) row_mean[i] <= l_q[i][DW-1:0];
               rnd <= '0;
               ph  <= PH_CDIV;
            end
            PH_CDIV: ph <= PH_CWAIT;
            PH_CWAIT: if (!any_busy) begin
               for (int j = 0; j < COLS; j++)
                  if ((j / ROWS) == int'(rnd)) col_mean[j] <= l_q[j % ROWS][DW-1:0];
               if (int'(rnd) == NRND - 1) ph <= PH_ADIV;
               else begin
                  rnd <= rnd + 1'b1;
                  ph  <= PH_CDIV;
               end
            end
            PH_ADIV: ph <= PH_AWAIT;
            PH_AWAIT: if (!any_busy) begin
               all_mean <= l_q[0][DW-1:0];
               col      <= '0;
               ph       <= PH_RES;
            end
            PH_RES: begin
               if (col == CIW'(COLS - 1)) ph <= PH_FDIV;
               else col <= col + 1'b1;
            end
            PH_FDIV: ph <= PH_FWAIT;
            PH_FWAIT: if (!any_busy) begin
               msr  <= l_q[0][MW-1:0];
               done <= 1'b1;
               ph   <= PH_IDLE;
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end

   // R6: result strobe lasts a single cycle
   p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R6: the engine is idle when the result is presented
   p_idle_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   // R7: the result changes only together with the strobe
   p_msr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(msr));
endmodule

// File: tb/msr_engine_bench.sv
module msr_engine_bench;
   localparam int R  = 4;
   localparam int C  = 6;
   localparam int DW = 16;
   localparam int MW = 2 * (DW + 2);

   typedef struct packed { int kind; int a; int b; } vec_t;
   localparam int NV = 6;
   localparam vec_t VECS [NV] = '{
      '{0, 11, 0},        // pseudo-random full range
      '{1, -1234, 0},     // constant matrix
      '{2, 300, -700},    // additive row/column pattern
      '{3, 0, 0},         // full-scale checkerboard
      '{4, 5, 0},         // small negative values
      '{5, -20000, 0}     // single spike
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [1:0] wr_row = '0;
   logic [2:0] wr_col = '0;
   logic signed [DW-1:0] wr_data = '0;
   logic start = 1'b0;
   logic busy, done;
   logic [MW-1:0] msr;

   int m [R][C];
   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   msr_engine #(.ROWS(R), .COLS(C), .DW(DW)) u_msr_engine (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col),
      .wr_data(wr_data), .start(start), .busy(busy), .done(done), .msr(msr)
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic void fill(input int kind, input int a, input int b);
      int s = a;
      for (int i = 0; i < R; i++)
         for (int j = 0; j < C; j++) begin
            s = s * 1103515245 + 12345;
            case (kind)
               0: m[i][j] = int'(shortint'(s[23:8]));
               1: m[i][j] = a;
               2: m[i][j] = a * i + b * j;
               3: m[i][j] = ((i + j) % 2 == 0) ? 32767 : -32768;
               4: m[i][j] = -int'(s[23:8] % 300);
               default: m[i][j] = (i == 3 && j == 5) ? a : 0;
            endcase
         end
   endfunction

   function automatic longint ref_msr();
      longint rs [R];
      longint cs [C];
      longint tot, am, r, acc;
      tot = 0; acc = 0;
      for (int i = 0; i < R; i++) rs[i] = 0;
      for (int j = 0; j < C; j++) cs[j] = 0;
      for (int i = 0; i < R; i++)
         for (int j = 0; j < C; j++) begin
            rs[i] += m[i][j];
            cs[j] += m[i][j];
         end
      for (int i = 0; i < R; i++) tot += rs[i];
      am = tot / (R * C);
      for (int i = 0; i < R; i++)
         for (int j = 0; j < C; j++) begin
            r = m[i][j] - rs[i] / C - cs[j] / R + am;
            acc += r * r;
         end
      return acc / (R * C);
   endfunction

   task automatic do_write(input int r, input int c, input int v);
      wr_en = 1'b1; wr_row = 2'(r); wr_col = 3'(c); wr_data = 16'(v);
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic load_all();
      for (int i = 0; i < R; i++)
         for (int j = 0; j < C; j++) do_write(i, j, m[i][j]);
   endtask

   // poke_at >= 0: at that cycle of the run, issue a write and a start (both to be ignored)
   // hold_chk: at cycle 5, check the previous result is still presented
   task automatic run(input int poke_at, input bit hold_chk, input longint hold_exp,
                      output longint res, output int lat);
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      lat = 0;
      res = -1;
      while (!done && lat < 5000) begin
         if (lat == poke_at) begin
            wr_en = 1'b1; wr_row = 2'd0; wr_col = 3'd0; wr_data = 16'sd999; start = 1'b1;
         end
         if (hold_chk && lat == 5)
            check(longint'(msr) == hold_exp, "R7 msr held during run", longint'(msr), hold_exp);
         @(posedge clk); #1;
         wr_en = 1'b0; start = 1'b0;
         lat++;
      end
      res = longint'(msr);
      check(done == 1'b1, "R6 done reached", longint'(done), 1);
      check(busy == 1'b0, "R6 busy low at done", longint'(busy), 0);
      @(posedge clk); #1;
      check(done == 1'b0, "R6 done single cycle", longint'(done), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
         $finish;
      end
   end

   initial begin
      longint res, exp, prev, orig;
      int lat, lat0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R10: reset state
      check(busy == 1'b0, "R10 busy after reset", longint'(busy), 0);
      check(done == 1'b0, "R10 done after reset", longint'(done), 0);
      check(msr == '0, "R10 msr after reset", longint'(msr), 0);

      lat0 = -1;
      prev = 0;
      for (int v = 0; v < NV; v++) begin
         fill(VECS[v].kind, VECS[v].a, VECS[v].b);
         load_all();
         exp = ref_msr();
         run(-1, v > 0, prev, res, lat);
         // R2 R3 R4 R5: means, residues and final average against the model
         check(res == exp, "R2 R3 R4 R5 msr vector", res, exp);
         if (lat0 < 0) lat0 = lat;
         check(lat == lat0, "R11 fixed latency", longint'(lat), longint'(lat0));
         prev = res;
      end

      // R1: change one element while idle and rerun
      m[2][4] = 12345;
      do_write(2, 4, 12345);
      exp = ref_msr();
      run(-1, 1'b1, prev, res, lat);
      check(res == exp, "R1 single write used", res, exp);
      orig = exp;

      // R8 R9: write and start while busy are ignored
      run(7, 1'b0, 0, res, lat);
      check(res == orig, "R8 busy write ignored", res, orig);
      check(lat == lat0, "R9 start while busy does not stretch run", longint'(lat), longint'(lat0));
      check(busy == 1'b0, "R9 no relaunch after done", longint'(busy), 0);
      run(-1, 1'b0, 0, res, lat);
      check(res == orig, "R8 matrix unchanged on rerun", res, orig);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule